// File: doc/BRIEF.md
# Tuner Configuration Register Slave

This block is the two-wire control port of a tuner. It watches an oversampled serial clock and data line, answers as a bus slave at one of two 7-bit addresses picked by a static select pin, and drives the data line only through an open-drain enable. Behind the port sits a file of twelve writable configuration bytes. Their contents leave the block as one flat vector. Two more indices return live status: calibration outcome, PLL lock, the chosen oscillator band and a tuning-voltage code.

A master writes by sending the register index and then any number of data bytes. The index steps forward after each byte. A master reads by setting the index with a write and then issuing a repeated START with the read bit set. Writing the fine-divider low byte fires a one-cycle pulse that launches the oscillator band calibration downstream. A power-on flag in the first status byte stays set from reset until that status byte has been read in a transaction that then ends with STOP.

Top module: `tuner_ctl_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 1100000 when `addrSel` is 0, or 1100001 when it is 1. Any other address gets no acknowledge and changes no register.
- R2: In a write, the byte after the address is the register index. Each following byte is stored at the current index, and the index then advances. The index byte and every data byte are acknowledged by pulling SDA low during the ninth clock.
- R3: After a repeated START with R/W=1, the block returns the byte at the current index MSB first. The index advances on each master ACK. After a master NACK the block releases SDA and drives nothing until the next START.
- R4: After reset the configuration bytes at indices 0 to 11 are 80, 23, 02, F6, 84, 01, C0, CC, 00, 00, 00, 00 (hex). Indices 2 to 4 hold a fine divider of 194,180 in their low 20 bits. In `cfgFlat`, index i occupies bits 8i+7 down to 8i.
- R5: A completed write to index 0x04 raises `calStart` for exactly one clock, after that byte's ACK clock. Writes to any other index do not raise it.
- R6: Index 0x0C reads as {power-on flag, calOk, calIdle, pllLock, 0000} from bit 7 down to bit 0. Index 0x0D reads as {vcoBand[4:0], tuneCode[2:0]}. Both are sampled when the byte starts to shift out.
- R7: The power-on flag is 1 after reset. It clears only when a transaction in which index 0x0C was returned ends with STOP. Reading only index 0x0D leaves it set.
- R8: The index advances from 0x0D to 0x00, and from any value above 0x0D to 0x00. Writes to 0x0C, 0x0D or any index above 0x0D are acknowledged but discarded. Reads of an index above 0x0D return 00.
- R9: A START or STOP that arrives while a byte is only partly shifted abandons that byte, and no register changes. A START begins a new address phase.
- R10: SDA is released at every STOP and after reset. The SDA enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| addrSel | input | 1 | Static select for the low bit of the slave address |
| sdaOe | output | 1 | When 1, the data line is pulled low |
| calOk | input | 1 | Band calibration succeeded |
| calIdle | input | 1 | Band calibration is not running |
| pllLock | input | 1 | PLL lock indication |
| vcoBand | input | 5 | Oscillator band currently in use |
| tuneCode | input | 3 | Tuning-voltage converter code |
| cfgFlat | output | 96 | All configuration bytes, index i at bits 8i+7:8i |
| calStart | output | 1 | One-cycle calibration launch pulse |

## Verification
A single multi-byte write can store the fine-divider low byte and advance the index in one strobe cycle. The launch pulse then rises while the next data byte is already shifting in. The bench provokes this with a burst that runs from index 0x02 through 0x05. It judges the result by requiring exactly one launch pulse, no pulse longer than one clock, and the burst's last byte landing correctly at 0x05. A second overlap comes from a read that returns status byte 1 and then continues into the next byte. That read must still report the flag as set, and the flag must read as clear only in the next transaction after STOP.

// File: rtl/tuner_ctl_pkg.sv
package tuner_ctl_pkg;

  // Strobes from the bus control to the register datapath
  typedef struct packed {
    logic       idxLoad;  // byteVal is a new register index
    logic       wrEn;     // store byteVal at index, then advance
    logic       idxInc;   // master acknowledged a read byte
    logic       rdTake;   // the byte at index is now shifting out
    logic       busStop;  // STOP seen on the bus
    logic [7:0] byteVal;
  } ctlStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_IDX, ST_WDAT, ST_ACK_ON, ST_ACK_OFF,
    ST_RD_BIT, ST_RD_REL, ST_RD_MACK, ST_RD_NEXT, ST_WAIT
  } busState_t;

  typedef enum logic [1:0] {AK_ADDR_W, AK_ADDR_R, AK_IDX, AK_DATA} ackKind_t;

endpackage

// File: rtl/tuner_ctl_fsm.sv
module tuner_ctl_fsm
  import tuner_ctl_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] SLAVE_BASE  = 7'h60
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       addrSel,
  input  logic [7:0] rdByte,
  output logic       sdaOe,
  output ctlStrobe_t strb
);

  localparam int CNT_W = $clog2(8);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclP, sdaP;
  logic sclRise, sclFall, isStart, isStop;
  busState_t state;
  ackKind_t  ackKind;
  logic [CNT_W-1:0] bitCnt;
  logic [7:0] rxSh, txSh, rxFull;
  logic [6:0] devAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclP    <= sclS;
      sdaP    <= sdaS;
    end
  end

  assign sclS    = sclPipe[SYNC_STAGES-1];
  assign sdaS    = sdaPipe[SYNC_STAGES-1];
  assign sclRise = sclS & ~sclP;
  assign sclFall = ~sclS & sclP;
  assign isStart = sclS & sclP & sdaP & ~sdaS;
  assign isStop  = sclS & sclP & ~sdaP & sdaS;
  assign rxFull  = {rxSh[6:0], sdaS};
  assign devAddr = {SLAVE_BASE[6:1], addrSel};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      ackKind <= AK_ADDR_W;
      bitCnt  <= '0;
      rxSh    <= '0;
      txSh    <= '0;
      sdaOe   <= 1'b0;
      strb    <= '0;
    end else begin
      strb <= '0;
      if (isStart) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (isStop) begin
        state        <= ST_IDLE;
        sdaOe        <= 1'b0;
        strb.busStop <= 1'b1;
      end else begin
        case (state)
          ST_ADDR, ST_IDX, ST_WDAT: if (sclRise) begin
            rxSh   <= rxFull;
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == 3'd7) begin
              if (state == ST_ADDR) begin
                if (rxFull[7:1] == devAddr) begin
                  ackKind <= rxFull[0] ? AK_ADDR_R : AK_ADDR_W;
                  state   <= ST_ACK_ON;
                end else begin
                  state <= ST_WAIT;
                end
              end else begin
                ackKind <= (state == ST_IDX) ? AK_IDX : AK_DATA;
                state   <= ST_ACK_ON;
              end
            end
          end
          ST_ACK_ON: if (sclFall) begin
            sdaOe <= 1'b1;
            state <= ST_ACK_OFF;
          end
          ST_ACK_OFF: if (sclFall) begin
            bitCnt <= '0;
            case (ackKind)
              AK_ADDR_W: begin
                sdaOe <= 1'b0;
                state <= ST_IDX;
              end
              AK_ADDR_R: begin
                txSh        <= rdByte;
                sdaOe       <= ~rdByte[7];
                strb.rdTake <= 1'b1;
                state       <= ST_RD_BIT;
              end
              AK_IDX: begin
                sdaOe        <= 1'b0;
                strb.idxLoad <= 1'b1;
                strb.byteVal <= rxSh;
                state        <= ST_WDAT;
              end
              default: begin
                sdaOe        <= 1'b0;
                strb.wrEn    <= 1'b1;
                strb.byteVal <= rxSh;
                state        <= ST_WDAT;
              end
            endcase
          end
          ST_RD_BIT: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == 3'd7) state <= ST_RD_REL;
            end else if (sclFall) begin
              txSh  <= {txSh[6:0], 1'b0};
              sdaOe <= ~txSh[6];
            end
          end
          ST_RD_REL: if (sclFall) begin
            sdaOe <= 1'b0;
            state <= ST_RD_MACK;
          end
          ST_RD_MACK: if (sclRise) begin
            if (!sdaS) begin
              strb.idxInc <= 1'b1;
              state       <= ST_RD_NEXT;
            end else begin
              state <= ST_WAIT;
            end
          end
          ST_RD_NEXT: if (sclFall) begin
            bitCnt      <= '0;
            txSh        <= rdByte;
            sdaOe       <= ~rdByte[7];
            strb.rdTake <= 1'b1;
            state       <= ST_RD_BIT;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/tuner_ctl_regs.sv
module tuner_ctl_regs
  import tuner_ctl_pkg::*;
#(
  parameter int NUM_CFG  = 12,
  parameter int TRIG_IDX = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           strb,
  input  logic                 calOk,
  input  logic                 calIdle,
  input  logic                 pllLock,
  input  logic [4:0]           vcoBand,
  input  logic [2:0]           tuneCode,
  output logic [7:0]           rdByte,
  output logic [NUM_CFG*8-1:0] cfgFlat,
  output logic                 calStart
);

  localparam int         NUM_STAT  = 2;
  localparam logic [7:0] STAT1_IDX = 8'(NUM_CFG);
  localparam logic [7:0] STAT2_IDX = 8'(NUM_CFG + 1);
  localparam logic [7:0] LAST_IDX  = 8'(NUM_CFG + NUM_STAT - 1);
  localparam logic [7:0] TRIG      = 8'(TRIG_IDX);

  function automatic logic [7:0] cfgDefault(input int i);
    case (i)
      0: return 8'h80;
      1: return 8'h23;
      2: return 8'h02;
      3: return 8'hF6;
      4: return 8'h84;
      5: return 8'h01;
      6: return 8'hC0;
      7: return 8'hCC;
      default: return 8'h00;
    endcase
  endfunction

  logic [7:0] idx;
  logic [7:0] cfg [NUM_CFG];
  logic porFlag, porPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx <= '0;
    end else if (strb.idxLoad) begin
      idx <= strb.byteVal;
    end else if (strb.wrEn || strb.idxInc) begin
      idx <= (idx >= LAST_IDX) ? 8'h00 : idx + 8'h01;
    end
  end

  for (genvar g = 0; g < NUM_CFG; g++) begin : gCfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cfg[g] <= cfgDefault(g);
      else if (strb.wrEn && idx == 8'(g)) cfg[g] <= strb.byteVal;
    end
    assign cfgFlat[g*8 +: 8] = cfg[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      porFlag  <= 1'b1;
      porPend  <= 1'b0;
      calStart <= 1'b0;
    end else begin
      calStart <= strb.wrEn && (idx == TRIG);
      if (strb.busStop) begin
        porPend <= 1'b0;
        if (porPend) porFlag <= 1'b0;
      end else if (strb.rdTake && idx == STAT1_IDX) begin
        porPend <= 1'b1;
      end
    end
  end

  always_comb begin
    rdByte = 8'h00;
    for (int i = 0; i < NUM_CFG; i++)
      if (idx == 8'(i)) rdByte = cfg[i];
    if (idx == STAT1_IDX) rdByte = {porFlag, calOk, calIdle, pllLock, 4'b0000};
    if (idx == STAT2_IDX) rdByte = {vcoBand, tuneCode};
  end

endmodule

// File: rtl/tuner_ctl_slave.sv
module tuner_ctl_slave
  import tuner_ctl_pkg::*;
#(
  parameter int         NUM_CFG     = 12,
  parameter int         TRIG_IDX    = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] SLAVE_BASE  = 7'h60
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic                 addrSel,
  output logic                 sdaOe,
  input  logic                 calOk,
  input  logic                 calIdle,
  input  logic                 pllLock,
  input  logic [4:0]           vcoBand,
  input  logic [2:0]           tuneCode,
  output logic [NUM_CFG*8-1:0] cfgFlat,
  output logic                 calStart
);

  ctlStrobe_t strb;
  logic [7:0] rdByte;

  tuner_ctl_fsm #(.SYNC_STAGES(SYNC_STAGES), .SLAVE_BASE(SLAVE_BASE)) u_fsm (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrSel(addrSel),
    .rdByte(rdByte), .sdaOe(sdaOe), .strb(strb)
  );

  tuner_ctl_regs #(.NUM_CFG(NUM_CFG), .TRIG_IDX(TRIG_IDX)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .calOk(calOk), .calIdle(calIdle),
    .pllLock(pllLock), .vcoBand(vcoBand), .tuneCode(tuneCode),
    .rdByte(rdByte), .cfgFlat(cfgFlat), .calStart(calStart)
  );

endmodule

// File: rtl/tuner_ctl_chk.sv
module tuner_ctl_chk (
  input logic       clk,
  input logic       rstN,
  input logic [4:0] strbBits,  // {idxLoad, wrEn, idxInc, rdTake, busStop}
  input logic       sdaOe,
  input logic       calStart
);

  // R5: launch pulse lasts one clock
  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    calStart |=> !calStart);

  // R5: launch pulse only follows a stored write
  a_r5_after_write: assert property (@(posedge clk) disable iff (!rstN)
    calStart |-> $past(strbBits[3]));

  // R2: at most one datapath action per cycle
  a_r2_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strbBits));

  // R10: a STOP leaves the data line released
  a_r10_stop_release: assert property (@(posedge clk) disable iff (!rstN)
    strbBits[0] |-> !sdaOe);

  // R3: a read byte never starts while the index is being reloaded
  a_r3_take_alone: assert property (@(posedge clk) disable iff (!rstN)
    strbBits[1] |-> !strbBits[4]);

endmodule

bind tuner_ctl_slave tuner_ctl_chk u_chk (
  .clk(clk), .rstN(rstN),
  .strbBits({strb.idxLoad, strb.wrEn, strb.idxInc, strb.rdTake, strb.busStop}),
  .sdaOe(sdaOe), .calStart(calStart)
);

// File: tb/sim_tuner_ctl_slave.sv
module sim_tuner_ctl_slave;

  localparam int CLK_PER = 10;
  localparam int QP      = 8;
  localparam int NCFG    = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, addrSel = 1'b0;
  logic calOk = 1'b1, calIdle = 1'b1, pllLock = 1'b0;
  logic [4:0] vcoBand = 5'h13;
  logic [2:0] tuneCode = 3'b010;
  logic sdaOe, calStart, sdaLine;
  logic [NCFG*8-1:0] cfgFlat;

  assign sdaLine = sdaM & ~sdaOe;

  tuner_ctl_slave u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .addrSel(addrSel),
    .sdaOe(sdaOe), .calOk(calOk), .calIdle(calIdle), .pllLock(pllLock),
    .vcoBand(vcoBand), .tuneCode(tuneCode), .cfgFlat(cfgFlat), .calStart(calStart)
  );

  always #(CLK_PER/2) clk = ~clk;

  int nTests = 0, nFail = 0;
  int pulseCnt = 0, doublePulse = 0, oeGlitch = 0;
  logic prevPulse = 1'b0, prevOe = 1'b0;
  logic [7:0] mdl [NCFG];
  logic mPor = 1'b1;
  logic [7:0] wbuf [8];
  logic [7:0] rxVal;
  logic [7:0] expVal [$];
  string expTag [$];
  event rdEv;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: pops one expected byte per received byte
  initial begin
    forever begin
      @(rdEv);
      if (expVal.size() == 0) chk(1'b0, "R3 unexpected byte", 32'(rxVal), 0);
      else begin
        logic [7:0] e;
        string t;
        e = expVal.pop_front();
        t = expTag.pop_front();
        chk(rxVal == e, t, 32'(rxVal), 32'(e));
      end
    end
  end

  always @(posedge clk) begin
    if (rstN) begin
      if (calStart) pulseCnt++;
      if (calStart && prevPulse) doublePulse++;
    end
    prevPulse <= calStart;
  end

  always @(negedge clk) begin
    if (rstN && sdaOe != prevOe && sclM) oeGlitch++;
    prevOe <= sdaOe;
  end

  task automatic wq();
    repeat (QP) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; wq(); sclM = 1'b1; wq(); sdaM = 1'b0; wq(); sclM = 1'b0; wq();
  endtask

  task automatic busStop();
    sdaM = 1'b0; wq(); sclM = 1'b1; wq(); sdaM = 1'b1; wq();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sdaM = b[7-i]; wq(); sclM = 1'b1; wq(); wq(); sclM = 1'b0; wq();
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input string req);
    logic got;
    sendBits(b, 8);
    sdaM = 1'b1; wq(); sclM = 1'b1; wq(); got = ~sdaLine; wq(); sclM = 1'b0; wq();
    chk(got == expAck, req, 32'(got), 32'(expAck));
  endtask

  task automatic recvByte(input bit mAck);
    logic [7:0] v;
    sdaM = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(); sclM = 1'b1; wq(); v = {v[6:0], sdaLine}; wq(); sclM = 1'b0;
    end
    wq(); sdaM = ~mAck; wq(); sclM = 1'b1; wq(); wq(); sclM = 1'b0; wq();
    sdaM = 1'b1;
    rxVal = v;
    ->rdEv;
  endtask

  function automatic int nxt(input int k);
    return (k >= 13) ? 0 : k + 1;
  endfunction

  function automatic logic [7:0] mByte(input int k);
    if (k < NCFG) return mdl[k];
    if (k == 12) return {mPor, calOk, calIdle, pllLock, 4'b0000};
    if (k == 13) return {vcoBand, tuneCode};
    return 8'h00;
  endfunction

  task automatic wrTxn(input logic [6:0] dev, input logic [7:0] idx, input int n, input string req);
    int k;
    busStart();
    sendByte({dev, 1'b0}, 1'b1, "R1 address ack");
    sendByte(idx, 1'b1, "R2 index ack");
    k = int'(idx);
    for (int i = 0; i < n; i++) begin
      sendByte(wbuf[i], 1'b1, req);
      if (k < NCFG) mdl[k] = wbuf[i];
      k = nxt(k);
    end
    busStop();
  endtask

  task automatic rdTxn(input logic [6:0] dev, input logic [7:0] idx, input int n, input string req);
    int k;
    bit sawStat = 0;
    k = int'(idx);
    for (int i = 0; i < n; i++) begin
      expVal.push_back(mByte(k));
      expTag.push_back(req);
      if (k == 12) sawStat = 1;
      k = nxt(k);
    end
    busStart();
    sendByte({dev, 1'b0}, 1'b1, "R1 address ack");
    sendByte(idx, 1'b1, "R2 index ack");
    busStart();
    sendByte({dev, 1'b1}, 1'b1, "R3 read address ack");
    for (int i = 0; i < n; i++) recvByte(i != n - 1);
    chk(sdaOe == 1'b0, "R3 released after NACK", 32'(sdaOe), 0);
    busStop();
    repeat (4) @(negedge clk);
    chk(expVal.size() == 0, "R3 all bytes returned", expVal.size(), 0);
    if (sawStat) mPor = 1'b0;
  endtask

  task automatic cfgCheck(input string req);
    logic [NCFG*8-1:0] e;
    for (int i = 0; i < NCFG; i++) e[i*8 +: 8] = mdl[i];
    chk(cfgFlat == e, req, 32'(cfgFlat[31:0]), 32'(e[31:0]));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int p0;
    mdl[0] = 8'h80; mdl[1] = 8'h23; mdl[2] = 8'h02; mdl[3] = 8'hF6;
    mdl[4] = 8'h84; mdl[5] = 8'h01; mdl[6] = 8'hC0; mdl[7] = 8'hCC;
    for (int i = 8; i < NCFG; i++) mdl[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R4 / R10 reset state
    chk(sdaOe == 1'b0, "R10 reset release", 32'(sdaOe), 0);
    chk(calStart == 1'b0, "R5 idle after reset", 32'(calStart), 0);
    cfgCheck("R4 reset defaults");

    // R7 / R6: read only status byte 2, flag must survive
    rdTxn(7'h60, 8'h0D, 1, "R6 status byte 2");
    // R4 / R6 / R7: whole map, flag still set in this read
    rdTxn(7'h60, 8'h00, 14, "R4 R6 R7 full readback");
    // R7: flag now clear, live status bits follow inputs
    pllLock = 1'b1; calOk = 1'b0;
    rdTxn(7'h60, 8'h0C, 1, "R7 flag cleared after STOP");

    // R2 / R5: burst across the trigger index
    p0 = pulseCnt;
    wbuf[0] = 8'h05; wbuf[1] = 8'hAA; wbuf[2] = 8'h55; wbuf[3] = 8'h3C;
    wrTxn(7'h60, 8'h02, 4, "R2 burst data ack");
    chk(pulseCnt - p0 == 1, "R5 one launch per trigger write", pulseCnt - p0, 1);
    cfgCheck("R2 burst stored");
    rdTxn(7'h60, 8'h02, 4, "R2 burst readback");

    // R5: other index gives no pulse
    p0 = pulseCnt;
    wbuf[0] = 8'h7E;
    wrTxn(7'h60, 8'h01, 1, "R2 single data ack");
    chk(pulseCnt == p0, "R5 no launch for index 1", pulseCnt - p0, 0);
    cfgCheck("R2 single stored");

    // R8: write through read-only indices and wrap
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    wrTxn(7'h60, 8'h0B, 4, "R8 ack on discarded index");
    cfgCheck("R8 wrap write");
    wbuf[0] = 8'h99;
    wrTxn(7'h60, 8'h20, 1, "R8 ack above range");
    cfgCheck("R8 out of range discarded");
    rdTxn(7'h60, 8'h20, 1, "R8 out of range reads zero");
    rdTxn(7'h60, 8'h0D, 2, "R8 read wrap");

    // R1: wrong address and address select
    busStart();
    sendByte(8'hC2, 1'b0, "R1 wrong address NACK");
    busStop();
    chk(sdaOe == 1'b0, "R1 line released", 32'(sdaOe), 0);
    cfgCheck("R1 no change on wrong address");
    addrSel = 1'b1;
    repeat (4) @(negedge clk);
    busStart();
    sendByte(8'hC0, 1'b0, "R1 old address NACK");
    busStop();
    wbuf[0] = 8'h5A;
    wrTxn(7'h61, 8'h09, 1, "R1 alternate address write");
    cfgCheck("R1 alternate address stored");
    rdTxn(7'h61, 8'h09, 1, "R1 alternate address read");

    // R9: STOP inside a data byte
    busStart();
    sendByte(8'hC2, 1'b1, "R9 address ack");
    sendByte(8'h06, 1'b1, "R9 index ack");
    sendBits(8'hFF, 4);
    busStop();
    cfgCheck("R9 STOP aborts byte");
    // R9: START inside a data byte, then a clean write
    busStart();
    sendByte(8'hC2, 1'b1, "R9 address ack");
    sendByte(8'h07, 1'b1, "R9 index ack");
    sendBits(8'h0F, 5);
    busStart();
    sendByte(8'hC2, 1'b1, "R9 restart address ack");
    sendByte(8'h08, 1'b1, "R9 restart index ack");
    sendByte(8'h66, 1'b1, "R9 restart data ack");
    busStop();
    mdl[8] = 8'h66;
    cfgCheck("R9 START aborts byte");

    chk(doublePulse == 0, "R5 pulse width one clock", doublePulse, 0);
    chk(oeGlitch == 0, "R10 SDA enable steady while SCL high", oeGlitch, 0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule